// File: doc/BRIEF.md
# Dual-Mode Pattern Bank Translator

This block turns a 13-bit pattern-table address from the picture unit into a physical character-memory address built from 1 KiB pages. The 8 KiB window is split into eight 1 KiB slots. For every slot the block presents a page number and a flag that chooses RAM or ROM. It also presents the translated address and the RAM flag for the slot that the current picture address selects.

The slot pages come from one of two schemes, and both sit behind a shared outer base. In the bank-register scheme, the slots are fed from a file of twelve bank registers written through a select/data register pair. In the normal ordering this gives two 2 KiB pairs and four single pages. In the extended ordering it gives eight independent single pages. In the flat scheme, a whole 8 KiB block is chosen from the outer base, optionally combined with a two-bit latch that is written through the upper processor window.

Top module: `chrx_top`

## Requirements
- R1: After reset the bank registers 0..11 hold 0,2,4,5,6,7,0,1,0xFE,0xFF,0xFF,0xFF. The bank-register scheme is active with normal ordering, no inversion, a full-size outer bank, base 0 and latch 0, so slot i shows page i.
- R2: Outer registers are written only when cpuAddr[15:12]=0x5 and cpuAddr[4]=1. cpuAddr[1:0] picks the register: 0 = mode, 2 = base, 3 = extension, and 1 has no effect here. Writes to any other address below 0x8000 change nothing.
- R3: In the bank-register scheme with normal ordering, with inner mask M (0xFF) and outer bits O = (base×8) & ~M, the slot pages are as follows. Slots 0/1 take bank 0 with bit 0 forced to 0/1. Slots 2/3 do the same with bank 1. Slots 4..7 take banks 2..5. Each value is masked with M and ORed with O.
- R4: Mode register bit 4 halves the outer bank size, so M becomes 0x7F and base bit 4 reaches page bit 7.
- R5: Extension register bit 1 selects extended ordering, in which slots 0..7 take banks 0,10,1,11,2,3,4,5, each ORed with base×8 and not masked. A write to the data register (cpuAddr[15:13]=100, cpuAddr[0]=1) targets the bank index held in the select register, cpuData[3:0] of a select write (cpuAddr[15:13]=100, cpuAddr[0]=0). In extended ordering the full 4-bit index is used and indexes 12..15 are dropped. In normal ordering only index bits [2:0] are used.
- R6: Select-register bit 7 XORs the slot index with 4 in the bank-register scheme and has no effect in the flat scheme.
- R7: Mode register bit 6 selects the flat scheme. With the latch sub-mode off, slot i shows base×8+i.
- R8: The latch sub-mode is on when extension register bit 2 or bit 6 is set. In that sub-mode, writes to 0x8000–0x9FFF or 0xC000–0xFFFF load cpuData[1:0] into the latch, and writes to 0xA000–0xBFFF do not. Slot i shows ((latch & K) | base)×8+i, where K is 1 with bit 4 of the mode register set and 3 with it clear.
- R9: A write to the base register clears the latch.
- R10: A slot selects RAM when chrRomPresent is 0, when mode register bit 5 is set, or when ramWinCfg and ramLowPages are both 1 and the slot page is at most 7.
- R11: chrAddr equals {page of slot ppuAddr[12:10], ppuAddr[9:0]}, and chrRam equals that slot's RAM flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | Processor write strobe, one cycle per write |
| cpuAddr | input | 16 | Processor write address |
| cpuData | input | 8 | Processor write data |
| chrRomPresent | input | 1 | Character ROM is fitted |
| ramWinCfg | input | 1 | Work-RAM window configuration enabled |
| ramLowPages | input | 1 | Low character pages are served from RAM |
| ppuAddr | input | 13 | Pattern-table address |
| slotPages | output | 88 | Eight 11-bit page numbers, slot 0 in the low bits |
| slotRam | output | 8 | Per-slot RAM select |
| chrAddr | output | 21 | Translated character-memory address |
| chrRam | output | 1 | RAM select for the addressed slot |

## Verification
The bench aims at the places where the two orderings and the two schemes part ways. Forcing bit 0 on the 2 KiB pairs is one such place. If the base is cleared at the wrong width, the outer bits would leak into the inner field when the bank size is halved. Extended ordering has its own traps: a design that took banks 10/11 in the wrong slots, or that let a dropped index 12 alias onto bank 4, would show wrong pages. The inversion bit must stay dead in the flat scheme. The latch must ignore the 0xA000–0xBFFF window and must be cleared by a base write, or the flat block would land on a stale page. The RAM select is driven across its page-7 threshold so that an off-by-one in the comparison shows up on slotRam.

// File: rtl/chrx_pkg.sv
package chrx_pkg;
  // Architectural constants of the translator
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int NUM_BANKS = 12;
  localparam int IDX_W     = 4;

  // Decoded write strobes from control to datapath
  typedef struct packed {
    logic modeWe;
    logic baseWe;
    logic extWe;
    logic selWe;
    logic dataWe;
    logic latchWe;
  } wrStrobe_t;
endpackage

// File: rtl/chrx_ctrl.sv
module chrx_ctrl
  import chrx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cnMode,
  output wrStrobe_t         stb
);
  localparam int TOP = ADDR_W - 1;

  logic outerHit;
  logic upperHit;
  logic unusedAddrBits;

  assign outerHit = cpuWe && (cpuAddr[TOP:TOP-3] == 4'h5) && cpuAddr[4];
  assign upperHit = cpuWe && cpuAddr[TOP];
  assign unusedAddrBits = ^{cpuAddr[TOP-4:5], cpuAddr[3:2]};

  always_comb begin
    stb         = '0;
    stb.modeWe  = outerHit && (cpuAddr[1:0] == 2'd0);
    stb.baseWe  = outerHit && (cpuAddr[1:0] == 2'd2);
    stb.extWe   = outerHit && (cpuAddr[1:0] == 2'd3);
    stb.selWe   = upperHit && (cpuAddr[TOP-1:TOP-2] == 2'b00) && !cpuAddr[0];
    stb.dataWe  = upperHit && (cpuAddr[TOP-1:TOP-2] == 2'b00) && cpuAddr[0];
    // latch window skips the second quarter of the upper half
    stb.latchWe = upperHit && cnMode && (cpuAddr[TOP-1:TOP-2] != 2'b01);
  end
endmodule

// File: rtl/chrx_datapath.sv
module chrx_datapath
  import chrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 10
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  wrStrobe_t                        stb,
  input  logic [DATA_W-1:0]                cpuData,
  input  logic                             chrRomPresent,
  input  logic                             ramWinCfg,
  input  logic                             ramLowPages,
  input  logic [SLOT_W+OFS_W-1:0]          ppuAddr,
  output logic [NUM_SLOTS*(DATA_W+SLOT_W)-1:0] slotPages,
  output logic [NUM_SLOTS-1:0]             slotRam,
  output logic [DATA_W+SLOT_W+OFS_W-1:0]   chrAddr,
  output logic                             chrRam,
  output logic                             cnMode
);
  localparam int PAGE_W = DATA_W + SLOT_W;

  function automatic logic [DATA_W-1:0] bankInit(int k);
    case (k)
      0: return DATA_W'(0);
      1: return DATA_W'(2);
      2: return DATA_W'(4);
      3: return DATA_W'(5);
      4: return DATA_W'(6);
      5: return DATA_W'(7);
      6: return DATA_W'(0);
      7: return DATA_W'(1);
      8: return {{(DATA_W-1){1'b1}}, 1'b0};
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  // configuration state
  logic              sizeHalf, forceRam, flatMode, extMode, invert;
  logic [DATA_W-1:0] base;
  logic [IDX_W-1:0]  curIdx;
  logic [1:0]        cnLatch;
  logic [DATA_W-1:0] bankReg [NUM_BANKS];
  logic [IDX_W-1:0]  wrIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeHalf <= 1'b0;
      forceRam <= 1'b0;
      flatMode <= 1'b0;
      extMode  <= 1'b0;
      cnMode   <= 1'b0;
      invert   <= 1'b0;
      base     <= '0;
      curIdx   <= '0;
      cnLatch  <= '0;
    end else begin
      if (stb.modeWe) begin
        sizeHalf <= cpuData[4];
        forceRam <= cpuData[5];
        flatMode <= cpuData[6];
      end
      if (stb.extWe) begin
        extMode <= cpuData[1];
        cnMode  <= cpuData[2] | cpuData[6];
      end
      if (stb.selWe) begin
        invert <= cpuData[DATA_W-1];
        curIdx <= cpuData[IDX_W-1:0];
      end
      if (stb.baseWe) begin
        base    <= cpuData;
        cnLatch <= '0;
      end else if (stb.latchWe) begin
        cnLatch <= cpuData[1:0];
      end
    end
  end

  assign wrIdx = extMode ? curIdx : {1'b0, curIdx[IDX_W-2:0]};

  for (genvar k = 0; k < NUM_BANKS; k++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN)
        bankReg[k] <= bankInit(k);
      else if (stb.dataWe && (wrIdx == IDX_W'(k)))
        bankReg[k] <= cpuData;
    end
  end

  // bank-register scheme, logical slot order
  logic [PAGE_W-1:0] baseShift, innerMask, outerBits;
  logic [PAGE_W-1:0] logPage [NUM_SLOTS];

  assign baseShift = {base, {SLOT_W{1'b0}}};
  assign innerMask = sizeHalf ? PAGE_W'({1'b0, {(DATA_W-1){1'b1}}})
                              : PAGE_W'({DATA_W{1'b1}});
  assign outerBits = baseShift & ~innerMask;

  for (genvar l = 0; l < NUM_SLOTS; l++) begin : gLog
    localparam int NORM_SRC = (l < 4) ? (l / 2) : (l - 2);
    localparam int EXT_SRC  = (l == 1) ? 10 : (l == 3) ? 11 :
                              (l == 0) ? 0  : (l == 2) ? 1  : (l - 2);
    logic [DATA_W-1:0] normRaw;
    if (l < 4) begin : gPair
      assign normRaw = {bankReg[NORM_SRC][DATA_W-1:1], 1'(l % 2)};
    end else begin : gSingle
      assign normRaw = bankReg[NORM_SRC];
    end
    assign logPage[l] = extMode ? (PAGE_W'(bankReg[EXT_SRC]) | baseShift)
                                : ((PAGE_W'(normRaw) & innerMask) | outerBits);
  end

  // flat scheme block number
  logic [DATA_W-1:0] cnMask, flatBlk;
  logic [SLOT_W-1:0] swapKey;

  assign cnMask  = !cnMode ? '0 : (sizeHalf ? DATA_W'(1) : DATA_W'(3));
  assign flatBlk = (DATA_W'(cnLatch) & cnMask) | base;
  assign swapKey = {invert, {(SLOT_W-1){1'b0}}};

  for (genvar p = 0; p < NUM_SLOTS; p++) begin : gSlot
    logic [PAGE_W-1:0] page;
    assign page = flatMode ? {flatBlk, SLOT_W'(p)}
                           : logPage[SLOT_W'(p) ^ swapKey];
    assign slotPages[p*PAGE_W +: PAGE_W] = page;
    assign slotRam[p] = !chrRomPresent || forceRam ||
                        (ramWinCfg && ramLowPages && (page <= PAGE_W'(7)));
  end

  logic [SLOT_W-1:0] slotSel;
  assign slotSel = ppuAddr[SLOT_W+OFS_W-1:OFS_W];
  assign chrAddr = {slotPages[slotSel*PAGE_W +: PAGE_W], ppuAddr[OFS_W-1:0]};
  assign chrRam  = slotRam[slotSel];
endmodule

// File: rtl/chrx_top.sv
module chrx_top
  import chrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  cpuWe,
  input  logic [ADDR_W-1:0]                     cpuAddr,
  input  logic [DATA_W-1:0]                     cpuData,
  input  logic                                  chrRomPresent,
  input  logic                                  ramWinCfg,
  input  logic                                  ramLowPages,
  input  logic [SLOT_W+OFS_W-1:0]               ppuAddr,
  output logic [NUM_SLOTS*(DATA_W+SLOT_W)-1:0]  slotPages,
  output logic [NUM_SLOTS-1:0]                  slotRam,
  output logic [DATA_W+SLOT_W+OFS_W-1:0]        chrAddr,
  output logic                                  chrRam
);
  wrStrobe_t stb;
  logic      cnMode;

  chrx_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .cpuWe   (cpuWe),
    .cpuAddr (cpuAddr),
    .cnMode  (cnMode),
    .stb     (stb)
  );

  chrx_datapath #(.DATA_W(DATA_W), .OFS_W(OFS_W)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cpuData       (cpuData),
    .chrRomPresent (chrRomPresent),
    .ramWinCfg     (ramWinCfg),
    .ramLowPages   (ramLowPages),
    .ppuAddr       (ppuAddr),
    .slotPages     (slotPages),
    .slotRam       (slotRam),
    .chrAddr       (chrAddr),
    .chrRam        (chrRam),
    .cnMode        (cnMode)
  );
endmodule

// File: rtl/chrx_chk.sv
module chrx_chk
  import chrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 cpuWe,
  input logic [ADDR_W-1:0]                    cpuAddr,
  input logic                                 chrRomPresent,
  input logic [NUM_SLOTS*(DATA_W+SLOT_W)-1:0] slotPages,
  input logic [NUM_SLOTS-1:0]                 slotRam,
  input logic                                 flatMode,
  input logic                                 cnMode,
  input logic [1:0]                           cnLatch
);
  localparam int PAGE_W = DATA_W + SLOT_W;
  localparam int TOP    = ADDR_W - 1;

  logic baseWr;
  assign baseWr = cpuWe && (cpuAddr[TOP:TOP-3] == 4'h5) && cpuAddr[4] &&
                  (cpuAddr[1:0] == 2'd2);

  for (genvar p = 0; p < NUM_SLOTS; p++) begin : gFlat
    // R7
    flat_slot_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      flatMode |-> (slotPages[p*PAGE_W +: SLOT_W] == SLOT_W'(p)));
  end

  // R10
  no_rom_all_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chrRomPresent |-> (slotRam == '1));

  // R9
  base_clears_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWr |=> (cnLatch == 2'd0));

  // R8
  mid_window_no_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && cnMode && (cpuAddr[TOP:TOP-2] == 3'b101)) |=> $stable(cnLatch));

  // R8
  latch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cnMode && !baseWr) |=> $stable(cnLatch));
endmodule

bind chrx_top chrx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .cpuWe         (cpuWe),
  .cpuAddr       (cpuAddr),
  .chrRomPresent (chrRomPresent),
  .slotPages     (slotPages),
  .slotRam       (slotRam),
  .flatMode      (uDp.flatMode),
  .cnMode        (uDp.cnMode),
  .cnLatch       (uDp.cnLatch)
);

// File: tb/chrx_top_bench.sv
`timescale 1ns/1ps
module chrx_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        chrRomPresent = 1'b1;
  logic        ramWinCfg = 1'b0;
  logic        ramLowPages = 1'b0;
  logic [12:0] ppuAddr = '0;
  logic [87:0] slotPages;
  logic [7:0]  slotRam;
  logic [20:0] chrAddr;
  logic        chrRam;

  always #4 clk = ~clk;

  chrx_top u_chrx_top (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .chrRomPresent(chrRomPresent), .ramWinCfg(ramWinCfg), .ramLowPages(ramLowPages),
    .ppuAddr(ppuAddr), .slotPages(slotPages), .slotRam(slotRam),
    .chrAddr(chrAddr), .chrRam(chrRam)
  );

  int checkCount = 0;
  int failCount  = 0;
  int cycles     = 0;
  bit running    = 1'b0;

  // reference state
  int mBank[12];
  int mBase, mLatch, mCur;
  bit mHalf, mForce, mFlat, mExt, mCn, mInv;

  task automatic modelReset();
    int init[12] = '{0, 2, 4, 5, 6, 7, 0, 1, 254, 255, 255, 255};
    foreach (mBank[k]) mBank[k] = init[k];
    mBase = 0; mLatch = 0; mCur = 0;
    mHalf = 0; mForce = 0; mFlat = 0; mExt = 0; mCn = 0; mInv = 0;
  endtask

  task automatic modelWrite(input int a, input int d);
    int idx;
    if ((a >> 12) == 5 && ((a >> 4) & 1) == 1) begin
      case (a & 3)
        0: begin mHalf = d[4]; mForce = d[5]; mFlat = d[6]; end
        2: begin mBase = d; mLatch = 0; end
        3: begin mExt = d[1]; mCn = d[2] || d[6]; end
        default: ;
      endcase
    end
    if (a >= 'h8000) begin
      if (mCn && !(a >= 'hA000 && a < 'hC000)) mLatch = d & 3;
      if ((a & 'hE001) == 'h8000) begin mInv = d[7]; mCur = d & 15; end
      if ((a & 'hE001) == 'h8001) begin
        idx = mExt ? mCur : (mCur & 7);
        if (idx < 12) mBank[idx] = d;
      end
    end
  endtask

  function automatic int refPage(int p);
    int order[8] = '{0, 10, 1, 11, 2, 3, 4, 5};
    int l, v, msk;
    if (mFlat) begin
      msk = mCn ? (mHalf ? 1 : 3) : 0;
      return (((mLatch & msk) | mBase) * 8) + p;
    end
    l = mInv ? (p ^ 4) : p;
    if (mExt) return mBank[order[l]] | (mBase * 8);
    msk = mHalf ? 127 : 255;
    v = (l < 4) ? ((mBank[l / 2] & 254) | (l % 2)) : mBank[l - 2];
    return (v & msk) | ((mBase * 8) & ~msk & 2047);
  endfunction

  function automatic int refRam(int p);
    return (!chrRomPresent || mForce || (ramWinCfg && ramLowPages && refPage(p) <= 7)) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    int sel;
    for (int p = 0; p < 8; p++) begin
      check(tag, $sformatf("slot%0d page", p), int'(slotPages[p*11 +: 11]), refPage(p));
      check("R10", $sformatf("slot%0d ram", p), int'(slotRam[p]), refRam(p));
    end
    sel = int'(ppuAddr[12:10]);
    check("R11", "chrAddr", int'(chrAddr), refPage(sel) * 1024 + int'(ppuAddr[9:0]));
    check("R11", "chrRam", int'(chrRam), refRam(sel));
  endtask

  function automatic string modeTag();
    if (mFlat) return mCn ? "R8" : "R7";
    return mExt ? "R5" : "R3";
  endfunction

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (running) compareAll(modeTag());
  end

  always @(negedge clk) ppuAddr <= ppuAddr + 13'h0457;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog (all R): actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = a; cpuData = d;
    @(posedge clk);
    #1 modelWrite(int'(a), int'(d));
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    settle();
    // R1: literal reset expectations
    for (int p = 0; p < 8; p++)
      check("R1", $sformatf("reset slot%0d", p), int'(slotPages[p*11 +: 11]), p);
    check("R1", "reset ram", int'(slotRam), 0);
    running = 1'b1;

    // R3: pair forcing
    cpuWrite(16'h8000, 8'h00); cpuWrite(16'h8001, 8'h13);
    settle();
    check("R3", "slot0 literal", int'(slotPages[0 +: 11]), 'h12);
    check("R3", "slot1 literal", int'(slotPages[11 +: 11]), 'h13);
    cpuWrite(16'h8000, 8'h01); cpuWrite(16'h8001, 8'h20);
    cpuWrite(16'h8000, 8'h02); cpuWrite(16'h8001, 8'h81);
    cpuWrite(16'h8000, 8'h05); cpuWrite(16'h8001, 8'hF0);
    compareAll("R3");

    // R6: inversion in bank scheme
    cpuWrite(16'h8000, 8'h80);
    settle();
    check("R6", "inverted slot4 literal", int'(slotPages[44 +: 11]), 'h12);
    compareAll("R6");

    // R4: half size with base
    cpuWrite(16'h5012, 8'h31);
    compareAll("R4");
    cpuWrite(16'h5010, 8'h10);
    compareAll("R4");

    // R2: non-register writes ignored
    cpuWrite(16'h5000, 8'h40);
    cpuWrite(16'h6012, 8'h77);
    cpuWrite(16'h7003, 8'h06);
    cpuWrite(16'h5011, 8'h7F);
    compareAll("R2");
    cpuWrite(16'h5010, 8'h00);
    cpuWrite(16'h8000, 8'h00);
    compareAll("R2");

    // R5: index masking in normal ordering, then extended ordering
    cpuWrite(16'h8000, 8'h0A); cpuWrite(16'h8001, 8'h3C);
    compareAll("R5");
    cpuWrite(16'h5013, 8'h02);
    cpuWrite(16'h8000, 8'h0A); cpuWrite(16'h8001, 8'h55);
    cpuWrite(16'h8000, 8'h0B); cpuWrite(16'h8001, 8'h66);
    cpuWrite(16'h8000, 8'h0C); cpuWrite(16'h8001, 8'h77);
    cpuWrite(16'h8000, 8'h0F); cpuWrite(16'h8001, 8'h99);
    compareAll("R5");
    cpuWrite(16'h8000, 8'h80);
    compareAll("R6");
    cpuWrite(16'h5012, 8'h02);
    compareAll("R5");

    // R7: flat scheme, inversion ignored
    cpuWrite(16'h5013, 8'h00);
    cpuWrite(16'h5010, 8'h40);
    compareAll("R7");
    cpuWrite(16'h8000, 8'h00);
    compareAll("R6");
    cpuWrite(16'h8000, 8'h80);
    compareAll("R6");

    // R8: latch sub-mode
    cpuWrite(16'h5012, 8'h10);
    cpuWrite(16'h5013, 8'h04);
    cpuWrite(16'h8000, 8'h03);
    compareAll("R8");
    cpuWrite(16'hA000, 8'h01);
    cpuWrite(16'hB001, 8'h02);
    compareAll("R8");
    cpuWrite(16'hE000, 8'h02);
    compareAll("R8");
    cpuWrite(16'h5010, 8'h50);
    compareAll("R8");
    cpuWrite(16'hC001, 8'h01);
    cpuWrite(16'h5013, 8'h40);
    cpuWrite(16'h9FFF, 8'h03);
    compareAll("R8");

    // R9: base write clears latch
    cpuWrite(16'h5012, 8'h08);
    compareAll("R9");
    cpuWrite(16'h5013, 8'h00);
    cpuWrite(16'h8000, 8'h02);
    compareAll("R9");

    // R10: RAM select paths
    cpuWrite(16'h5012, 8'h00);
    cpuWrite(16'h5010, 8'h00);
    @(negedge clk) begin ramWinCfg = 1'b1; ramLowPages = 1'b1; end
    settle();
    compareAll("R10");
    cpuWrite(16'h8000, 8'h00); cpuWrite(16'h8001, 8'h08);
    compareAll("R10");
    @(negedge clk) ramLowPages = 1'b0;
    settle();
    compareAll("R10");
    cpuWrite(16'h5010, 8'h20);
    compareAll("R10");
    cpuWrite(16'h5010, 8'h00);
    @(negedge clk) chrRomPresent = 1'b0;
    settle();
    compareAll("R10");
    @(negedge clk) chrRomPresent = 1'b1;

    // R11: sweep addresses for a while
    repeat (40) @(negedge clk);
    compareAll("R11");

    running = 1'b0;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule